// File: doc/BRIEF.md
# Timer interrupt and DMA request controller

This block sits between a timer's event sources and the CPU. It receives single-cycle pulses for two capture events, two compare events and counter wrap (overflow or underflow). It also receives end-of-block pulses from a DMA engine. It turns these into one level interrupt request, or into DMA request pulses for the capture-0 and compare-0 channels. An eight-bit mask register decides which path each event takes. Software reads and writes this register through a simple select/write-enable port.

While the DMA enable of capture 0 or compare 0 is set, an event on that channel asks for a DMA transfer and raises no per-event interrupt. The channel's interrupt mask bit then serves the end-of-block interrupt of that channel. When a block transfer ends, the matching DMA enable clears itself. A status bit reports which channel the most recent DMA request served.

A second register holds a DMA counter pointer for software. One of its bits can flip on each compare-0 end of block, which lets the DMA engine swap between two buffers. Interrupt sources stay pending until software clears them with a write-one-to-clear input.

Top module: `tmr_irq_dma`

## Requirements
- R1: After reset, the mask register reads 00h, the pointer register reads 00h, `irq` is 0, both DMA request lines are 0 and `dma_src` is 0.
- R2: A write with `cfg_we`=1 and `cfg_sel`=0 loads `cfg_wdata` into the mask register. Field positions are: bit 7 global enable, bit 6 capture-0 DMA enable, bit 5 capture-0 mask, bit 4 capture-1 mask, bit 3 compare-0 DMA enable, bit 2 compare-0 mask, bit 1 compare-1 mask, bit 0 wrap mask. `cfg_rdata` shows the new value from the cycle after the write edge whenever `cfg_sel`=0.
- R3: While mask bit 7 is 0, `irq` is 0 whatever the pending sources and the other mask bits hold.
- R4: The pending sources are latched on the event edge. Bit positions are: bit 0 wrap, bit 1 compare 1, bit 2 compare 0, bit 3 compare-0 end of block, bit 4 capture 1, bit 5 capture 0, bit 6 capture-0 end of block. A pending bit stays set until a `pend_clr` bit at its position is 1. A new event wins over a clear in the same cycle. `irq` is mask bit 7 AND the OR over the pending bits, each ANDed with its mask. Bits 6 and 5 use mask bit 5, bits 3 and 2 use mask bit 2, bit 4 uses mask bit 4, bit 1 uses mask bit 1 and bit 0 uses mask bit 0. `irq` follows from the cycle after the event edge.
- R5: A capture-0 or compare-0 event that occurs while its DMA enable (mask bit 6 or 3) is 1 drives its DMA request line high for exactly the next cycle, and does not set its per-event pending bit.
- R6: An end-of-block pulse clears its DMA enable bit (capture 0: bit 6, compare 0: bit 3). A software write to the mask register in the same cycle cannot keep that bit set.
- R7: An end-of-block pulse sets its end-of-block pending bit, so that the channel's interrupt mask bit raises `irq` for the end of block.
- R8: `dma_src` becomes 0 with each capture-0 DMA request and 1 with each compare-0 DMA request, and holds its value otherwise. If both requests occur in the same cycle, 0 wins. It also reads as bit 1 of the pointer register and cannot be written.
- R9: A write with `cfg_sel`=1 loads bits 7:2 and bit 0 of the pointer register. A compare-0 end-of-block pulse while `swap_en`=1 inverts pointer bit 2, unless a pointer write happens in the same cycle, in which case the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 mask, 1 pointer |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| ev_cap0 | input | 1 | Capture-0 event pulse |
| ev_cap1 | input | 1 | Capture-1 event pulse |
| ev_cmp0 | input | 1 | Compare-0 event pulse |
| ev_cmp1 | input | 1 | Compare-1 event pulse |
| ev_wrap | input | 1 | Counter overflow/underflow pulse |
| eob_cap0 | input | 1 | Capture-0 end-of-block pulse |
| eob_cmp0 | input | 1 | Compare-0 end-of-block pulse |
| pend_clr | input | 7 | Write-one-to-clear of pending sources |
| swap_en | input | 1 | Enables the pointer bit-2 swap toggle |
| irq | output | 1 | Interrupt request |
| dma_req_cap0 | output | 1 | Capture-0 DMA request pulse |
| dma_req_cmp0 | output | 1 | Compare-0 DMA request pulse |
| dma_src | output | 1 | Channel served: 0 capture 0, 1 compare 0 |

## Verification
Every register in the block is updated on the edge that samples its inputs. The DMA request pulses, `dma_src`, the pending bits and both registers therefore change one cycle after the stimulus. `irq` and `cfg_rdata` follow those registers combinationally in the same cycle. The bench drives inputs two nanoseconds after a rising edge and advances a reference model by one step at the next edge. Two nanoseconds after that edge it compares every output with the model. The directed cases for same-cycle collisions are checked at that same point, right after the edge that resolves them.

// File: rtl/tmr_irq_dma.sv
module tmr_irq_dma #(
  parameter int DW = 8,
  parameter int NSRC = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          ev_cap0,
  input  logic          ev_cap1,
  input  logic          ev_cmp0,
  input  logic          ev_cmp1,
  input  logic          ev_wrap,
  input  logic          eob_cap0,
  input  logic          eob_cmp0,
  input  logic [NSRC-1:0] pend_clr,
  input  logic          swap_en,
  output logic          irq,
  output logic          dma_req_cap0,
  output logic          dma_req_cmp0,
  output logic          dma_src
);
  localparam int B_GIE = DW - 1;
  localparam int B_C0D = DW - 2;
  localparam int B_C0I = DW - 3;
  localparam int B_C1I = DW - 4;
  localparam int B_M0D = DW - 5;
  localparam int B_M0I = DW - 6;
  localparam int B_M1I = DW - 7;
  localparam int B_WRI = DW - 8;

  logic [DW-1:0]   mask_q, mask_d;
  logic [DW-1:0]   ptr_q;
  logic [NSRC-1:0] pend_q, pend_set, pend_en;
  logic            wr_mask, wr_ptr;
  logic            req_cap0_d, req_cmp0_d;

  assign wr_mask = cfg_we && !cfg_sel;
  assign wr_ptr  = cfg_we && cfg_sel;

  always_comb begin
    mask_d = wr_mask ? cfg_wdata : mask_q;
    if (eob_cap0) mask_d[B_C0D] = 1'b0;
    if (eob_cmp0) mask_d[B_M0D] = 1'b0;
  end

  assign req_cap0_d = ev_cap0 && mask_q[B_C0D];
  assign req_cmp0_d = ev_cmp0 && mask_q[B_M0D];

  assign pend_set = {eob_cap0,
                     ev_cap0 && !mask_q[B_C0D],
                     ev_cap1,
                     eob_cmp0,
                     ev_cmp0 && !mask_q[B_M0D],
                     ev_cmp1,
                     ev_wrap};

  assign pend_en = {mask_q[B_C0I], mask_q[B_C0I], mask_q[B_C1I],
                    mask_q[B_M0I], mask_q[B_M0I], mask_q[B_M1I],
                    mask_q[B_WRI]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q       <= '0;
      ptr_q        <= '0;
      pend_q       <= '0;
      dma_req_cap0 <= 1'b0;
      dma_req_cmp0 <= 1'b0;
      dma_src      <= 1'b0;
    end else begin
      mask_q       <= mask_d;
      pend_q       <= (pend_q & ~pend_clr) | pend_set;
      dma_req_cap0 <= req_cap0_d;
      dma_req_cmp0 <= req_cmp0_d;
      if (req_cap0_d)      dma_src <= 1'b0;
      else if (req_cmp0_d) dma_src <= 1'b1;
      if (wr_ptr)                    ptr_q <= {cfg_wdata[DW-1:2], 1'b0, cfg_wdata[0]};
      else if (eob_cmp0 && swap_en)  ptr_q[2] <= ~ptr_q[2];
    end
  end

  assign irq       = mask_q[B_GIE] && |(pend_q & pend_en);
  assign cfg_rdata = cfg_sel ? {ptr_q[DW-1:2], dma_src, ptr_q[0]} : mask_q;
endmodule

module tmr_irq_dma_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          cfg_sel,
  input logic          ev_cap0,
  input logic          ev_cmp0,
  input logic          eob_cap0,
  input logic          eob_cmp0,
  input logic          swap_en,
  input logic          irq,
  input logic          dma_req_cap0,
  input logic          dma_req_cmp0,
  input logic          dma_src,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] ptr_q
);
  a_r3_gie_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[DW-1] |-> !irq);
  a_r6_eob_clears_cap0: assert property (@(posedge clk) disable iff (!rst_n)
    eob_cap0 |=> !mask_q[DW-2]);
  a_r6_eob_clears_cmp0: assert property (@(posedge clk) disable iff (!rst_n)
    eob_cmp0 |=> !mask_q[DW-5]);
  a_r5_req_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_cap0 |-> $past(ev_cap0));
  a_r5_cmp_req_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_cmp0 |-> $past(ev_cmp0));
  a_r8_src_cap0: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_cap0 |-> !dma_src);
  a_r9_swap_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (eob_cmp0 && swap_en && !(cfg_we && cfg_sel)) |=> (ptr_q[2] != $past(ptr_q[2])));
endmodule

bind tmr_irq_dma tmr_irq_dma_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_tmr_irq_dma.sv
module test_tmr_irq_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic ev_cap0 = 0, ev_cap1 = 0, ev_cmp0 = 0, ev_cmp1 = 0, ev_wrap = 0;
  logic eob_cap0 = 0, eob_cmp0 = 0, swap_en = 0;
  logic [6:0] pend_clr = '0;
  logic irq, dma_req_cap0, dma_req_cmp0, dma_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_mask, m_ptr;
  logic [6:0] m_pend;
  logic m_req0, m_req1, m_src;

  always #4 clk = ~clk;

  tmr_irq_dma i_tmr_irq_dma (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_irq();
    logic [6:0] en;
    en = {m_mask[5], m_mask[5], m_mask[4], m_mask[2], m_mask[2], m_mask[1], m_mask[0]};
    return m_mask[7] & |(m_pend & en);
  endfunction

  function automatic logic [7:0] exp_rdata();
    return cfg_sel ? {m_ptr[7:2], m_src, m_ptr[0]} : m_mask;
  endfunction

  task automatic check_all();
    chk("R3 R4 R7 irq", {7'd0, irq}, {7'd0, exp_irq()});
    chk("R5 dma_req_cap0", {7'd0, dma_req_cap0}, {7'd0, m_req0});
    chk("R5 dma_req_cmp0", {7'd0, dma_req_cmp0}, {7'd0, m_req1});
    chk("R8 dma_src", {7'd0, dma_src}, {7'd0, m_src});
    if (cfg_sel) chk("R9 pointer readback", cfg_rdata, exp_rdata());
    else         chk("R2 R6 mask readback", cfg_rdata, exp_rdata());
  endtask

  task automatic step();
    logic [7:0] nm, np;
    logic [6:0] set;
    logic r0, r1, ns;
    nm = (cfg_we && !cfg_sel) ? cfg_wdata : m_mask;
    if (eob_cap0) nm[6] = 1'b0;
    if (eob_cmp0) nm[3] = 1'b0;
    r0 = ev_cap0 & m_mask[6];
    r1 = ev_cmp0 & m_mask[3];
    ns = r0 ? 1'b0 : (r1 ? 1'b1 : m_src);
    set = {eob_cap0, ev_cap0 & ~m_mask[6], ev_cap1, eob_cmp0, ev_cmp0 & ~m_mask[3], ev_cmp1, ev_wrap};
    np = m_ptr;
    if (cfg_we && cfg_sel) np = {cfg_wdata[7:2], 1'b0, cfg_wdata[0]};
    else if (eob_cmp0 && swap_en) np[2] = ~np[2];
    @(posedge clk);
    #2;
    m_mask = nm; m_ptr = np; m_pend = (m_pend & ~pend_clr) | set;
    m_req0 = r0; m_req1 = r1; m_src = ns;
    check_all();
  endtask

  task automatic idle();
    cfg_we = 0; ev_cap0 = 0; ev_cap1 = 0; ev_cmp0 = 0; ev_cmp1 = 0; ev_wrap = 0;
    eob_cap0 = 0; eob_cmp0 = 0; pend_clr = '0; swap_en = 0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    idle(); cfg_we = 1; cfg_sel = sel; cfg_wdata = d; step(); cfg_we = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_mask = '0; m_ptr = '0; m_pend = '0; m_req0 = 0; m_req1 = 0; m_src = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset irq", {7'd0, irq}, 8'd0);
    chk("R1 reset req", {6'd0, dma_req_cap0, dma_req_cmp0}, 8'd0);
    chk("R1 reset src", {7'd0, dma_src}, 8'd0);
    chk("R1 reset mask", cfg_rdata, 8'h00);
    cfg_sel = 1; #1;
    chk("R1 reset pointer", cfg_rdata, 8'h00);
    cfg_sel = 0;
    rst_n = 1;

    wr(0, 8'h37);
    chk("R2 mask written", cfg_rdata, 8'h37);
    idle(); ev_wrap = 1; step(); idle();
    chk("R3 gie off blocks irq", {7'd0, irq}, 8'd0);
    wr(0, 8'h81);
    chk("R4 pending wrap raises irq", {7'd0, irq}, 8'd1);
    idle(); ev_wrap = 1; pend_clr = 7'h01; step(); idle();
    chk("R4 set wins over clear", {7'd0, irq}, 8'd1);
    pend_clr = 7'h01; step(); idle();
    chk("R4 clear drops irq", {7'd0, irq}, 8'd0);

    wr(0, 8'hE0);
    ev_cap0 = 1; step(); idle();
    chk("R5 cap0 dma request", {7'd0, dma_req_cap0}, 8'd1);
    chk("R5 no per-event irq", {7'd0, irq}, 8'd0);
    step();
    chk("R5 request one cycle", {7'd0, dma_req_cap0}, 8'd0);

    cfg_we = 1; cfg_sel = 0; cfg_wdata = 8'hE0; eob_cap0 = 1; step(); idle();
    chk("R6 hw clear wins", {7'd0, cfg_rdata[6]}, 8'd0);
    chk("R7 eob irq", {7'd0, irq}, 8'd1);
    pend_clr = 7'h7F; step(); idle();

    wr(0, 8'h08);
    ev_cmp0 = 1; step(); idle();
    chk("R8 src compare", {7'd0, dma_src}, 8'd1);

    wr(1, 8'hA5);
    chk("R9 pointer write", cfg_rdata, 8'hA7);
    eob_cmp0 = 1; swap_en = 1; step(); idle();
    chk("R9 swap toggles bit 2", cfg_rdata, 8'hA3);
    cfg_we = 1; cfg_wdata = 8'h10; eob_cmp0 = 1; swap_en = 1; step(); idle();
    chk("R9 write wins over swap", cfg_rdata, 8'h12);

    for (int i = 0; i < 4000; i++) begin
      cfg_we   = ($urandom % 8) == 0;
      cfg_sel  = ($urandom % 3) == 0;
      cfg_wdata = 8'($urandom);
      ev_cap0  = ($urandom % 5) == 0;
      ev_cap1  = ($urandom % 7) == 0;
      ev_cmp0  = ($urandom % 5) == 0;
      ev_cmp1  = ($urandom % 7) == 0;
      ev_wrap  = ($urandom % 9) == 0;
      eob_cap0 = ($urandom % 11) == 0;
      eob_cmp0 = ($urandom % 11) == 0;
      swap_en  = $urandom % 2;
      pend_clr = (($urandom % 4) == 0) ? 7'($urandom) : 7'd0;
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule